// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller with Edge Interrupts

This block is a general-purpose I/O controller for 64 or 96 pins, reached through a simple 32-bit register bus with separate read and write strobes. Software sees eight functional register groups. Each group is as many 32-bit words wide as the pin count needs. The groups hold the pin input levels, the pin directions, the output latch, the rising-edge and falling-edge detect enables, the sticky edge status and the alternate-function selectors.

Pad inputs are brought into the clock domain through a two-flop synchroniser. An edge is recognised when two consecutive synchronised samples differ. Enabled edges set a sticky status bit, and a single interrupt line stays high while any status bit is set. Outputs change only through write-1-to-set and write-1-to-clear words, so software never needs a read-modify-write to drive a pin. Each pin has a 2-bit alternate-function field. A nonzero field removes the pin's output enable from GPIO control and leaves the pad to another peripheral.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every register is 0: all pins are inputs, the output latch is low, detection is disabled, the status is clear, every alternate field is 0 and irq is low.
- R2: Registers are addressed by byte address, word aligned. The group order is level(0), direction(1), set(2), clear(3), rising enable(4), falling enable(5), status(6), alternate(7). With NW = NPINS/32, group g word w sits at g*NW*4 + w*4, and pin p uses word p/32, bit p%32 (groups 0 to 6).
- R3: The level group returns the synchronised pad input levels, which follow a pad change two clock edges later. Writes to the level group change nothing.
- R4: Writing 1s to a set word drives those pins' output latch bits high. Writing 1s to a clear word drives them low. Zero bits change nothing. Reading the set or the clear group returns the output latch.
- R5: A direction bit of 1 makes the pin an output. pad_oe of a pin equals its direction bit while its alternate field is 0.
- R6: With the rising enable set, a synchronised low-to-high transition sets the pin's status bit three clock edges after the pad changes.
- R7: With the falling enable set, a high-to-low transition sets the status bit. A rising transition with only the falling enable set does not. With both enables set, either direction sets it.
- R8: Status bits are sticky. Writing 1 clears a bit, writing 0 leaves it alone, and writing all ones clears the whole word.
- R9: If an enabled edge is detected at the same clock edge that a write-1-to-clear hits the same status bit, the bit stays set.
- R10: irq is high exactly when at least one status bit is set.
- R11: The alternate group spans 2*NW words at byte 7*NW*4, with 16 pins per word. Pin p has its 2-bit field at bit (p%16)*2 of alternate word p/16. The field appears on alt_sel[2p+1:2p]. A nonzero field forces pad_oe of that pin low.
- R12: Reads of addresses outside the map or not word aligned return 0, and writes to them change nothing.
- R13: Read data appears on bus_rdata after the clock edge that samples bus_rd, and bus_rdata is 0 in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | AW | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | NPINS | Asynchronous pad input levels |
| pad_out | output | NPINS | Output latch towards the pads |
| pad_oe | output | NPINS | Pad output enable |
| alt_sel | output | 2*NPINS | Alternate-function field of each pin |
| irq | output | 1 | High while any edge status bit is set |

## Verification
Register writes take effect at the clock edge that samples the strobe, so pad_out and pad_oe are compared at the falling edge that follows. Read data is due one edge after the read strobe, and a scoreboard holds each expected word until that cycle. A pad change reaches the level group after two edges, and status and irq after three. The interrupt is checked at both the second and the third falling edge after the pad change. For the collision case the bench times the clear write to land on the exact edge where the status bit would be set.

// File: rtl/gpio_edge_pkg.sv
// Package: shared constants and the register group encoding of the GPIO
// controller. Assumes a 32-bit data bus.
package gpio_edge_pkg;
    localparam int WORD_W = 32;
    localparam int NUM_GROUPS = 8;

    // Register groups in address order
    typedef enum logic [2:0] {
        GRP_LEVEL = 3'd0,
        GRP_DIR   = 3'd1,
        GRP_SET   = 3'd2,
        GRP_CLR   = 3'd3,
        GRP_RISE  = 3'd4,
        GRP_FALL  = 3'd5,
        GRP_STAT  = 3'd6,
        GRP_ALT   = 3'd7
    } grp_e;
endpackage

// File: rtl/gpio_addr_decode.sv
// Module: turns a byte address into a register group and a word index
// within that group. Groups 0..6 span NWORDS words each and the alternate
// group spans 2*NWORDS words. Assumes word-aligned accesses; anything else
// misses.
module gpio_addr_decode
    import gpio_edge_pkg::*;
#(
    parameter int NWORDS = 2,
    parameter int AW     = 8,
    parameter int IW     = 2
) (
    input  logic [AW-1:0] addr,
    output grp_e          grp,
    output logic [IW-1:0] word,
    output logic          hit
);
    localparam int ALT_BASE = (NUM_GROUPS - 1) * NWORDS;
    localparam int MAP_END  = ALT_BASE + 2 * NWORDS;

    logic [AW-3:0] widx;
    assign widx = addr[AW-1:2];

    // Purpose: map a word index onto a group and a word within it
    always_comb begin
        hit  = 1'b0;
        grp  = GRP_LEVEL;
        word = '0;
        if (addr[1:0] == 2'b00) begin
            if (int'(widx) < ALT_BASE) begin
                hit  = 1'b1;
                grp  = grp_e'(3'(int'(widx) / NWORDS));
                word = IW'(int'(widx) % NWORDS);
            end else if (int'(widx) < MAP_END) begin
                hit  = 1'b1;
                grp  = GRP_ALT;
                word = IW'(int'(widx) - ALT_BASE);
            end
        end
    end
endmodule

// File: rtl/gpio_pin_sync.sv
// Module: two-flop synchroniser for every pad input, plus a third stage
// holding the previous synchronised sample for edge detection. Assumes the
// pad inputs are asynchronous to clk and that pulses last longer than two
// clocks.
module gpio_pin_sync #(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pad_in,
    output logic [N-1:0] level,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] meta_q, sync_q, prev_q;

    // Purpose: sample the pads through two flops and keep the prior sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level = sync_q;
    assign rise  = sync_q & ~prev_q;
    assign fall  = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_status_bank.sv
// Module: sticky per-pin edge status with write-1-to-clear. A detected edge
// takes priority over a clear in the same cycle. Assumes the clear mask is
// a single-cycle pulse.
module gpio_status_bank #(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rise,
    input  logic [N-1:0] fall,
    input  logic [N-1:0] rise_en,
    input  logic [N-1:0] fall_en,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] status,
    output logic         any
);
    logic [N-1:0] hit_edge;
    assign hit_edge = (rise & rise_en) | (fall & fall_en);

    // Purpose: hold status bits, clear on request, set on enabled edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            status <= (status & ~clr_mask) | hit_edge;
        end
    end

    assign any = |status;
endmodule

// File: rtl/gpio_edge_ctrl.sv
// Module: top of the GPIO controller. Decodes the register bus, holds the
// direction, output, detect-enable and alternate-function registers, and
// drives the pad and interrupt outputs. Assumes NPINS is 64 or 96 and that
// AW covers 9*NPINS/8 bytes.
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int NPINS = 64,
    parameter int AW    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      bus_addr,
    input  logic               bus_wr,
    input  logic [WORD_W-1:0]  bus_wdata,
    input  logic               bus_rd,
    output logic [WORD_W-1:0]  bus_rdata,
    input  logic [NPINS-1:0]   pad_in,
    output logic [NPINS-1:0]   pad_out,
    output logic [NPINS-1:0]   pad_oe,
    output logic [2*NPINS-1:0] alt_sel,
    output logic               irq
);
    localparam int NW  = NPINS / WORD_W;
    localparam int NAW = 2 * NW;
    localparam int IW  = $clog2(NAW);

    grp_e          grp;
    logic [IW-1:0] word;
    logic          hit;
    logic          wr_hit;

    logic [NPINS-1:0]   dir_q, out_q, rise_en_q, fall_en_q;
    logic [2*NPINS-1:0] alt_q;
    logic [NPINS-1:0]   level, rise, fall, status, clr_mask;
    logic               any_pending;
    logic [WORD_W-1:0]  rd_word;

    gpio_addr_decode #(.NWORDS(NW), .AW(AW), .IW(IW)) dec_i (
        .addr (bus_addr),
        .grp  (grp),
        .word (word),
        .hit  (hit)
    );

    gpio_pin_sync #(.N(NPINS)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .level  (level),
        .rise   (rise),
        .fall   (fall)
    );

    gpio_status_bank #(.N(NPINS)) stat_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .fall     (fall),
        .rise_en  (rise_en_q),
        .fall_en  (fall_en_q),
        .clr_mask (clr_mask),
        .status   (status),
        .any      (any_pending)
    );

    assign wr_hit = bus_wr && hit;

    // Purpose: build the write-1-to-clear mask for the status group
    always_comb begin
        clr_mask = '0;
        if (wr_hit && grp == GRP_STAT) begin
            for (int w = 0; w < NW; w++) begin
                if (word == IW'(w)) clr_mask[w*WORD_W +: WORD_W] = bus_wdata;
            end
        end
    end

    // Purpose: apply bus writes to the control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q     <= '0;
            out_q     <= '0;
            rise_en_q <= '0;
            fall_en_q <= '0;
            alt_q     <= '0;
        end else if (wr_hit) begin
            for (int w = 0; w < NW; w++) begin
                if (word == IW'(w)) begin
                    case (grp)
                        GRP_DIR:  dir_q[w*WORD_W +: WORD_W]     <= bus_wdata;
                        GRP_SET:  out_q[w*WORD_W +: WORD_W]     <= out_q[w*WORD_W +: WORD_W] | bus_wdata;
                        GRP_CLR:  out_q[w*WORD_W +: WORD_W]     <= out_q[w*WORD_W +: WORD_W] & ~bus_wdata;
                        GRP_RISE: rise_en_q[w*WORD_W +: WORD_W] <= bus_wdata;
                        GRP_FALL: fall_en_q[w*WORD_W +: WORD_W] <= bus_wdata;
                        default:  ;
                    endcase
                end
            end
            for (int w = 0; w < NAW; w++) begin
                if (grp == GRP_ALT && word == IW'(w)) alt_q[w*WORD_W +: WORD_W] <= bus_wdata;
            end
        end
    end

    // Purpose: select the word addressed by a read
    always_comb begin
        rd_word = '0;
        for (int w = 0; w < NW; w++) begin
            if (word == IW'(w)) begin
                case (grp)
                    GRP_LEVEL:        rd_word = level[w*WORD_W +: WORD_W];
                    GRP_DIR:          rd_word = dir_q[w*WORD_W +: WORD_W];
                    GRP_SET, GRP_CLR: rd_word = out_q[w*WORD_W +: WORD_W];
                    GRP_RISE:         rd_word = rise_en_q[w*WORD_W +: WORD_W];
                    GRP_FALL:         rd_word = fall_en_q[w*WORD_W +: WORD_W];
                    GRP_STAT:         rd_word = status[w*WORD_W +: WORD_W];
                    default:          ;
                endcase
            end
        end
        for (int w = 0; w < NAW; w++) begin
            if (grp == GRP_ALT && word == IW'(w)) rd_word = alt_q[w*WORD_W +: WORD_W];
        end
    end

    // Purpose: register read data; zero when idle or on a miss
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= (bus_rd && hit) ? rd_word : '0;
        end
    end

    // Purpose: gate each pin's output enable by its alternate field
    for (genvar p = 0; p < NPINS; p++) begin : g_oe
        assign pad_oe[p] = dir_q[p] && (alt_q[2*p +: 2] == 2'b00);
    end

    assign pad_out = out_q;
    assign alt_sel = alt_q;
    assign irq     = any_pending;
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
// Module: property checker for gpio_edge_ctrl, attached with bind below.
// Assumes word 0 of each group sits at group_index*NW*4.
module gpio_edge_ctrl_chk #(
    parameter int NPINS = 64,
    parameter int AW    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    bus_addr,
    input logic             bus_wr,
    input logic             wd0,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic [1:0]       alt0,
    input logic             irq,
    input logic [NPINS-1:0] dir_q,
    input logic [NPINS-1:0] rise_en_q,
    input logic [NPINS-1:0] fall_en_q
);
    localparam int NW = NPINS / 32;
    localparam logic [AW-1:0] SET0 = AW'(2 * NW * 4);
    localparam logic [AW-1:0] CLR0 = AW'(3 * NW * 4);
    localparam logic [AW-1:0] LVL_END = AW'(NW * 4);

    // R4
    set_drives_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SET0 && wd0) |=> pad_out[0]);

    // R4
    clr_drives_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CLR0 && wd0) |=> !pad_out[0]);

    // R3
    level_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr < LVL_END) |=> ($stable(pad_out) && $stable(pad_oe)));

    // R5
    oe_needs_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~dir_q) == '0);

    // R11
    oe_needs_gpio_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe[0] |-> (alt0 == 2'b00));

    // R8
    irq_falls_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(bus_wr));

    // R6
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|(rise_en_q | fall_en_q)));
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.NPINS(NPINS), .AW(AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .wd0       (bus_wdata[0]),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .alt0      (alt_sel[1:0]),
    .irq       (irq),
    .dir_q     (dir_q),
    .rise_en_q (rise_en_q),
    .fall_en_q (fall_en_q)
);

// File: tb/gpio_edge_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_tb_top;
    localparam int NPINS = 64;
    localparam int AW    = 8;

    typedef struct {
        logic [31:0] exp;
        string       req;
        logic [7:0]  addr;
    } rd_item_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [AW-1:0]      bus_addr = '0;
    logic               bus_wr = 1'b0;
    logic [31:0]        bus_wdata = '0;
    logic               bus_rd = 1'b0;
    logic [31:0]        bus_rdata;
    logic [NPINS-1:0]   pad_in = '0;
    logic [NPINS-1:0]   pad_out;
    logic [NPINS-1:0]   pad_oe;
    logic [2*NPINS-1:0] alt_sel;
    logic               irq;

    int       n_checks = 0;
    int       n_errors = 0;
    logic     rd_seen = 1'b0;
    logic     done = 1'b0;
    rd_item_t sb_q[$];

    always #2.5 clk = ~clk;

    gpio_edge_ctrl #(.NPINS(NPINS), .AW(AW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .alt_sel   (alt_sel),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: issue a read and push the expected word onto the scoreboard
    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string req);
        rd_item_t it;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        it.exp = e; it.req = req; it.addr = a;
        sb_q.push_back(it);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) rd_seen <= bus_rd;

    // Monitor: data is due at the falling edge after the sampling edge
    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb_q.size() == 0) begin
                n_checks++; n_errors++;
                $display("FAIL R13: unexpected read data actual=%0h expected=none", bus_rdata);
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                n_checks++;
                if (bus_rdata !== it.exp) begin
                    n_errors++;
                    $display("FAIL %s: addr=%0h actual=%0h expected=%0h", it.req, it.addr, bus_rdata, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pad_oe", 128'(pad_oe), 128'(0));
        chk("R1 pad_out", 128'(pad_out), 128'(0));
        chk("R1 irq", 128'(irq), 128'(0));
        chk("R1 alt_sel", 128'(alt_sel), 128'(0));
        chk("R13 rdata idle", 128'(bus_rdata), 128'(0));
        rd(8'h08, 32'h0, "R1 dir");
        rd(8'h30, 32'h0, "R1 status");
        rd(8'h38, 32'h0, "R1 alt");

        // R2 / R5 direction word 1 covers pins 32..63
        wr(8'h0C, 32'h5);
        chk("R5 pad_oe", 128'(pad_oe), 128'({32'h5, 32'h0}));
        rd(8'h0C, 32'h5, "R2 dir word1");
        rd(8'h08, 32'h0, "R2 dir word0");

        // R4 set / clear
        wr(8'h10, 32'hF0);
        chk("R4 set", 128'(pad_out), 128'(64'hF0));
        wr(8'h18, 32'h30);
        chk("R4 clear", 128'(pad_out), 128'(64'hC0));
        wr(8'h10, 32'h0);
        chk("R4 zero set", 128'(pad_out), 128'(64'hC0));
        wr(8'h18, 32'h0);
        chk("R4 zero clear", 128'(pad_out), 128'(64'hC0));
        rd(8'h18, 32'hC0, "R4 read clear group");
        rd(8'h10, 32'hC0, "R4 read set group");

        // R3 level read and ignored writes
        pad_in[63:32] = 32'hA5;
        idle(3);
        rd(8'h04, 32'hA5, "R3 level word1");
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, 32'h0, "R3 level write ignored");
        chk("R3 pad_out after level write", 128'(pad_out), 128'(64'hC0));

        // R6 rising edge on pin 3 with exact timing
        wr(8'h20, 32'h8);
        @(negedge clk);
        pad_in[3] = 1'b1;
        idle(2);
        chk("R6 irq not yet", 128'(irq), 128'(0));
        idle(1);
        chk("R6 irq third edge", 128'(irq), 128'(1));
        rd(8'h30, 32'h8, "R6 status");

        // R7 falling only on pin 40
        wr(8'h2C, 32'h100);
        pad_in[40] = 1'b1;
        idle(4);
        rd(8'h34, 32'h0, "R7 rise ignored");
        pad_in[40] = 1'b0;
        idle(4);
        rd(8'h34, 32'h100, "R7 falling sets");

        // R8 sticky, write 0 keeps, all ones clears
        wr(8'h30, 32'h0);
        rd(8'h30, 32'h8, "R8 write zero keeps");
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h34, 32'hFFFF_FFFF);
        rd(8'h30, 32'h0, "R8 all ones word0");
        rd(8'h34, 32'h0, "R8 all ones word1");
        chk("R8 irq cleared", 128'(irq), 128'(0));

        // R7 both edges on pin 2
        wr(8'h20, 32'hC);
        wr(8'h28, 32'h4);
        pad_in[2] = 1'b1;
        idle(4);
        rd(8'h30, 32'h4, "R7 both rise");
        wr(8'h30, 32'h4);
        rd(8'h30, 32'h0, "R8 single clear");
        pad_in[2] = 1'b0;
        idle(4);
        rd(8'h30, 32'h4, "R7 both fall");

        // R10 irq with two pending bits
        pad_in[3] = 1'b0;
        pad_in[40] = 1'b1;
        idle(4);
        pad_in[40] = 1'b0;
        idle(4);
        rd(8'h34, 32'h100, "R10 pin40 pending");
        chk("R10 irq two pending", 128'(irq), 128'(1));
        wr(8'h30, 32'h4);
        chk("R10 irq one left", 128'(irq), 128'(1));
        wr(8'h34, 32'h100);
        chk("R10 irq none", 128'(irq), 128'(0));

        // R9 clear collides with a new edge on pin 5
        wr(8'h20, 32'h2C);
        pad_in[5] = 1'b1;
        idle(4);
        rd(8'h30, 32'h20, "R9 first edge");
        pad_in[5] = 1'b0;
        idle(4);
        @(negedge clk);
        pad_in[5] = 1'b1;
        @(negedge clk);
        wr(8'h30, 32'h20);
        rd(8'h30, 32'h20, "R9 edge wins over clear");
        chk("R9 irq held", 128'(irq), 128'(1));
        wr(8'h30, 32'h20);
        rd(8'h30, 32'h0, "R9 later clear");

        // R11 alternate fields
        wr(8'h08, 32'h2);
        chk("R5 pin1 output", 128'(pad_oe), 128'({32'h5, 32'h2}));
        wr(8'h38, 32'h8);
        chk("R11 pin1 oe masked", 128'(pad_oe), 128'({32'h5, 32'h0}));
        chk("R11 pin1 field", 128'(alt_sel[3:2]), 128'(2));
        wr(8'h40, 32'h10);
        chk("R11 pin34 oe masked", 128'(pad_oe), 128'({32'h1, 32'h0}));
        chk("R11 pin34 field", 128'(alt_sel[69:68]), 128'(1));
        rd(8'h40, 32'h10, "R11 alt word2");

        // R12 unused and unaligned addresses
        wr(8'h48, 32'hFFFF_FFFF);
        wr(8'h11, 32'hFFFF_FFFF);
        chk("R12 pad_out unchanged", 128'(pad_out), 128'(64'hC0));
        chk("R12 pad_oe unchanged", 128'(pad_oe), 128'({32'h1, 32'h0}));
        rd(8'h48, 32'h0, "R12 unused read");
        rd(8'h0D, 32'h0, "R12 unaligned read");
        rd(8'h80, 32'h0, "R12 far read");

        idle(2);
        chk("R13 scoreboard drained", 128'(sb_q.size()), 128'(0));
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule